// File: doc/BRIEF.md
# Low-Side Channel Fault Qualifier

This block sits between the command logic of a multi-channel low-side switch and the gate drivers. Each channel gets its own copy of the qualification logic. The copy watches two analog comparator results and lets the commanded drive through to the gate only while the channel is healthy.

An overcurrent is considered only while the channel is commanded on. An open load (or a short to ground) is considered only while it is commanded off. Either condition must stay present over a programmable number of timebase ticks before it becomes a fault.

A qualified overcurrent does not latch the channel off for good. The channel rests for a long programmable interval and then tries again. A load that stays shorted therefore sees only short on-pulses, which is a low duty cycle. Fault flags are held for serial readback and are cleared by a pulse that marks the end of a serial frame. An open-drain enable pulls a shared status line low while any channel has a flag set.

Top module: `ldrv_fault_guard`

## Requirements
- R1: `gate_on[i]` is 1 exactly when `chan_req[i]` is 1 and channel i is not resting after an overcurrent; it is 0 whenever `chan_req[i]` is 0.
- R2: With `chan_req[i]` high and `oc_cmp[i]` held high, the overcurrent qualifies at the SENSE_TICKS-th `tick` pulse sampled with the condition present. On the following cycle `gate_on[i]` is 0 and `fault_flag[i]` is 1.
- R3: If `oc_cmp[i]` is low in any cycle before qualification, the tick count for that channel restarts from zero.
- R4: `oc_cmp[i]` has no effect while `chan_req[i]` is low: no flag is set, however many ticks pass.
- R5: With `chan_req[i]` low, `ol_cmp[i]` held high over SENSE_TICKS tick pulses sets `fault_flag[i]`. `ol_cmp[i]` has no effect while `chan_req[i]` is high.
- R6: After an overcurrent qualifies, the channel rests with its gate off for REST_TICKS tick pulses while the request stays high. On the cycle after the last of those ticks the gate is on again, and a new overcurrent must again persist SENSE_TICKS ticks.
- R7: Dropping `chan_req[i]` during the rest interval ends it at once. When the request returns, the gate turns on in the same cycle.
- R8: An overcurrent flag stays set after the condition is gone and clears only on a `frame_clr` pulse. If a qualification and a clear pulse fall in the same cycle, the flag is set.
- R9: A `frame_clr` pulse clears an open-load flag only if `ol_cmp[i]` is low in that cycle; otherwise the flag stays set.
- R10: `status_pull_en` is 1 (pull the status line low) exactly when at least one bit of `fault_flag` is 1.
- R11: Channels are independent: a fault on one channel changes no other channel's gate or flag.
- R12: A change of `chan_req[i]` restarts the sense count, so ticks counted before the channel was switched off do not carry over to the next on period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase pulse (one sense interval) |
| frame_clr | input | 1 | One-cycle pulse at the end of a serial frame; clears flags |
| chan_req | input | NUM_CH | Per-channel on command (serial OR parallel) |
| oc_cmp | input | NUM_CH | Overcurrent comparator, 1 = over limit |
| ol_cmp | input | NUM_CH | Open-load comparator, 1 = drain above threshold while off |
| gate_on | output | NUM_CH | Gated drive to the output switch |
| fault_flag | output | NUM_CH | Per-channel fault for serial readback |
| status_pull_en | output | 1 | 1 = pull the shared open-drain status line low |

## Verification
The bench looks for an off-by-one in the sense count. A design that got this wrong would trip one tick early, or would keep counting across a gap in the overcurrent or across an off period; the gap and re-enable sequences catch both, since such a design would flag where no flag is due. The rest interval is timed tick by tick on both sides of its end. A wrong limit would show the gate back on, or still off, one tick away from the expected point.

The bench also drops the request in the middle of a rest interval. A design that held the rest state would keep the gate low. It then sends clear pulses while the open load is still present, and later after it has gone. A design that cleared unconditionally would lose the open-load flag, and one that never cleared would leave the status line pulled.

// File: rtl/ldrv_pkg.sv
package ldrv_pkg;

    typedef enum logic {
        MODE_RUN  = 1'b0,
        MODE_REST = 1'b1
    } rest_mode_e;

    typedef struct packed {
        logic oc_flag;
        logic ol_flag;
    } flag_pair_t;

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/ldrv_persist_filter.sv
module ldrv_persist_filter #(
    parameter int unsigned HOLD_TICKS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic tick,
    output logic hit
);
    localparam int unsigned CW = ldrv_pkg::cnt_width(HOLD_TICKS);
    localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } filt_state_t;

    filt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        hit  = 1'b0;
        if (!arm) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (st_q.cnt == LAST) begin
                hit      = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/ldrv_rest_timer.sv
module ldrv_rest_timer #(
    parameter int unsigned REST_TICKS = 63
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic start,
    input  logic tick,
    output logic resting
);
    import ldrv_pkg::*;

    localparam int unsigned CW = cnt_width(REST_TICKS);
    localparam logic [CW-1:0] LAST = CW'(REST_TICKS - 1);

    typedef struct packed {
        rest_mode_e    mode;
        logic [CW-1:0] cnt;
    } rest_state_t;

    rest_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!req) begin
            st_d.mode = MODE_RUN;
            st_d.cnt  = '0;
        end else if (start) begin
            st_d.mode = MODE_REST;
            st_d.cnt  = '0;
        end else if (st_q.mode == MODE_REST && tick) begin
            if (st_q.cnt == LAST) begin
                st_d.mode = MODE_RUN;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: MODE_RUN, cnt: '0};
        else        st_q <= st_d;
    end

    assign resting = (st_q.mode == MODE_REST);

endmodule

// File: rtl/ldrv_chan_guard.sv
module ldrv_chan_guard #(
    parameter int unsigned SENSE_TICKS = 1,
    parameter int unsigned REST_TICKS  = 63
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clr,
    input  logic req,
    input  logic oc,
    input  logic ol,
    output logic gate,
    output logic flag
);
    import ldrv_pkg::*;

    logic resting;
    logic oc_arm, ol_arm;
    logic oc_hit, ol_hit;
    flag_pair_t fl_d, fl_q;

    assign oc_arm = req & ~resting & oc;
    assign ol_arm = ~req & ol;

    ldrv_persist_filter #(.HOLD_TICKS(SENSE_TICKS)) u_oc_filt (
        .clk  (clk),
        .rst_n(rst_n),
        .arm  (oc_arm),
        .tick (tick),
        .hit  (oc_hit)
    );

    ldrv_persist_filter #(.HOLD_TICKS(SENSE_TICKS)) u_ol_filt (
        .clk  (clk),
        .rst_n(rst_n),
        .arm  (ol_arm),
        .tick (tick),
        .hit  (ol_hit)
    );

    ldrv_rest_timer #(.REST_TICKS(REST_TICKS)) u_rest (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req),
        .start  (oc_hit),
        .tick   (tick),
        .resting(resting)
    );

    always_comb begin
        fl_d = fl_q;
        if (oc_hit)   fl_d.oc_flag = 1'b1;
        else if (clr) fl_d.oc_flag = 1'b0;
        if (ol_hit)         fl_d.ol_flag = 1'b1;
        else if (clr && !ol) fl_d.ol_flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign gate = req & ~resting;
    assign flag = fl_q.oc_flag | fl_q.ol_flag;

endmodule

// File: rtl/ldrv_fault_guard.sv
module ldrv_fault_guard #(
    parameter int unsigned NUM_CH      = 4,
    parameter int unsigned SENSE_TICKS = 1,
    parameter int unsigned REST_TICKS  = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              frame_clr,
    input  logic [NUM_CH-1:0] chan_req,
    input  logic [NUM_CH-1:0] oc_cmp,
    input  logic [NUM_CH-1:0] ol_cmp,
    output logic [NUM_CH-1:0] gate_on,
    output logic [NUM_CH-1:0] fault_flag,
    output logic              status_pull_en
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        ldrv_chan_guard #(
            .SENSE_TICKS(SENSE_TICKS),
            .REST_TICKS (REST_TICKS)
        ) u_ch (
            .clk  (clk),
            .rst_n(rst_n),
            .tick (tick),
            .clr  (frame_clr),
            .req  (chan_req[i]),
            .oc   (oc_cmp[i]),
            .ol   (ol_cmp[i]),
            .gate (gate_on[i]),
            .flag (fault_flag[i])
        );
    end

    assign status_pull_en = |fault_flag;

endmodule

// File: rtl/ldrv_fault_guard_chk.sv
module ldrv_fault_guard_chk #(
    parameter int unsigned NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              frame_clr,
    input logic [NUM_CH-1:0] chan_req,
    input logic [NUM_CH-1:0] gate_on,
    input logic [NUM_CH-1:0] fault_flag,
    input logic              status_pull_en
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_p
        AST_GATE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            gate_on[i] |-> chan_req[i]); // R1

        AST_FLAG_SET_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(fault_flag[i]) |-> $past(tick)); // R2

        AST_FLAG_CLEAR_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(fault_flag[i]) |-> $past(frame_clr)); // R8

        AST_CUTOFF_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(gate_on[i]) && chan_req[i] && $past(chan_req[i])) |-> fault_flag[i]); // R6

        AST_RETRY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(gate_on[i]) && chan_req[i] && $past(chan_req[i])) |-> $past(tick)); // R6
    end

    AST_STATUS_ON_FLAG_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(fault_flag) > $countones($past(fault_flag))) |-> status_pull_en); // R10

endmodule

bind ldrv_fault_guard ldrv_fault_guard_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (tick),
    .frame_clr     (frame_clr),
    .chan_req      (chan_req),
    .gate_on       (gate_on),
    .fault_flag    (fault_flag),
    .status_pull_en(status_pull_en)
);

// File: tb/tb_ldrv_fault_guard.sv
`timescale 1ns/1ps
module tb_ldrv_fault_guard;

    localparam int NCH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic frame_clr = 1'b0;
    logic [NCH-1:0] chan_req = '0;
    logic [NCH-1:0] oc_cmp = '0;
    logic [NCH-1:0] ol_cmp = '0;
    logic [NCH-1:0] gate_on, fault_flag;
    logic status_pull_en;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    typedef struct {
        string          tag;
        logic [NCH-1:0] g;
        logic [NCH-1:0] f;
        logic           s;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #2.5 clk = ~clk;

    ldrv_fault_guard #(
        .NUM_CH(NCH), .SENSE_TICKS(2), .REST_TICKS(6)
    ) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .frame_clr(frame_clr),
        .chan_req(chan_req), .oc_cmp(oc_cmp), .ol_cmp(ol_cmp),
        .gate_on(gate_on), .fault_flag(fault_flag), .status_pull_en(status_pull_en)
    );

    // monitor: compares at mid-cycle
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            n_vec++;
            if (gate_on !== it.g || fault_flag !== it.f || status_pull_en !== it.s) begin
                n_bad++;
                $display("FAIL %s: gate=%b flag=%b stat=%b, expected gate=%b flag=%b stat=%b",
                         it.tag, gate_on, fault_flag, status_pull_en, it.g, it.f, it.s);
            end
        end
    end

    task automatic drv(input logic [NCH-1:0] rq, oc, ol, input logic tk, cs);
        @(posedge clk);
        #1;
        chan_req = rq; oc_cmp = oc; ol_cmp = ol; tick = tk; frame_clr = cs;
    endtask

    task automatic want(input string tag, input logic [NCH-1:0] g, f, input logic s);
        sb_item_t it;
        it.tag = tag; it.g = g; it.f = f; it.s = s;
        sb_q.push_back(it);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset state, R1 R10
        drv(4'h0, 4'h0, 4'h0, 0, 0); want("R1 reset idle", 4'h0, 4'h0, 0);
        drv(4'h1, 4'h0, 4'h0, 0, 0); want("R1 gate follows request", 4'h1, 4'h0, 0);

        // R2 overcurrent qualifies on 2nd tick
        drv(4'h1, 4'h1, 4'h0, 1, 0);
        drv(4'h1, 4'h1, 4'h0, 0, 0); want("R2 one tick not enough", 4'h1, 4'h0, 0);
        drv(4'h1, 4'h1, 4'h0, 1, 0);
        drv(4'h1, 4'h1, 4'h0, 0, 0); want("R2 qualified cutoff", 4'h0, 4'h1, 1);

        // R6 rest interval of 6 ticks
        repeat (5) drv(4'h1, 4'h0, 4'h0, 1, 0);
        drv(4'h1, 4'h0, 4'h0, 0, 0); want("R6 still resting after 5 ticks", 4'h0, 4'h1, 1);
        drv(4'h1, 4'h0, 4'h0, 1, 0);
        drv(4'h1, 4'h0, 4'h0, 0, 0); want("R6 retry after 6 ticks", 4'h1, 4'h1, 1);

        // R8 latched until frame clear
        drv(4'h1, 4'h0, 4'h0, 0, 1); want("R8 flag held without clear", 4'h1, 4'h1, 1);
        drv(4'h1, 4'h0, 4'h0, 0, 0); want("R8 cleared by frame pulse", 4'h1, 4'h0, 0);

        // R3 gap restarts count
        drv(4'h1, 4'h1, 4'h0, 1, 0);
        drv(4'h1, 4'h0, 4'h0, 0, 0);
        drv(4'h1, 4'h1, 4'h0, 1, 0);
        drv(4'h1, 4'h1, 4'h0, 0, 0); want("R3 gap restarts count", 4'h1, 4'h0, 0);
        drv(4'h1, 4'h1, 4'h0, 1, 0);
        drv(4'h1, 4'h1, 4'h0, 0, 0); want("R6 requalify after retry", 4'h0, 4'h1, 1);

        // R7 request drop ends rest at once
        repeat (3) drv(4'h1, 4'h1, 4'h0, 1, 0);
        drv(4'h0, 4'h0, 4'h0, 0, 0); want("R7 request low", 4'h0, 4'h1, 1);
        drv(4'h1, 4'h0, 4'h0, 0, 0); want("R7 gate back immediately", 4'h1, 4'h1, 1);
        drv(4'h1, 4'h0, 4'h0, 0, 1);
        drv(4'h0, 4'h0, 4'h0, 0, 0); want("R8 clear after R7", 4'h0, 4'h0, 0);

        // R4 overcurrent ignored when off
        repeat (3) drv(4'h0, 4'h1, 4'h0, 1, 0);
        drv(4'h0, 4'h1, 4'h0, 0, 0); want("R4 oc ignored while off", 4'h0, 4'h0, 0);

        // R12 off period restarts count
        drv(4'h1, 4'h1, 4'h0, 1, 0);
        drv(4'h0, 4'h1, 4'h0, 0, 0);
        drv(4'h1, 4'h1, 4'h0, 1, 0);
        drv(4'h1, 4'h1, 4'h0, 0, 0); want("R12 count restarted by off", 4'h1, 4'h0, 0);

        // R5 open load on ch0 (off), ignored on ch1 (on)
        drv(4'h2, 4'h0, 4'h3, 1, 0);
        drv(4'h2, 4'h0, 4'h3, 1, 0);
        drv(4'h2, 4'h0, 4'h3, 0, 0); want("R5 open load off-state only", 4'h2, 4'h1, 1);

        // R9 conditional clear
        drv(4'h0, 4'h0, 4'h1, 0, 1);
        drv(4'h0, 4'h0, 4'h1, 0, 0); want("R9 clear blocked while present", 4'h0, 4'h1, 1);
        drv(4'h0, 4'h0, 4'h0, 0, 1);
        drv(4'h0, 4'h0, 4'h0, 0, 0); want("R9 clear once gone", 4'h0, 4'h0, 0);

        // R11 independence
        drv(4'hC, 4'h4, 4'h0, 1, 0);
        drv(4'hC, 4'h4, 4'h0, 1, 0);
        drv(4'hC, 4'h4, 4'h0, 0, 0); want("R11 only ch2 affected", 4'h8, 4'h4, 1);
        drv(4'hC, 4'h0, 4'h0, 0, 1);
        drv(4'h0, 4'h0, 4'h0, 0, 0); want("R10 status released", 4'h0, 4'h0, 0);

        drv(4'h0, 4'h0, 4'h0, 0, 0);
        @(posedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule